// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block sits on the target side of a shared bus and serves reads from several initiators out of a slower memory-mapped backend. It holds one read at a time. A fresh read is answered with retry in the same cycle. The controller records who asked and for which address, then starts one backend read. The initiator is expected to come back later with the same request. When it does and the data has arrived, the controller hands over the word and the transaction completes. Until that happens, every other read is turned away with retry and nothing about it is kept.

An initiator that never returns would otherwise block the bridge for good. An optional discard timer guards against this: it drops the held data after a programmable number of cycles.

Top module: `delayed_read_ctrl`

## Requirements
- R1: When the controller is idle, a read gets retry (code 01) in the same cycle. On the next clock edge `be_req` rises, with `be_addr` equal to the requested address.
- R2: While a backend read is outstanding, a read with a different initiator ID or a different address gets retry. It changes neither `be_addr` nor the request that completes later.
- R3: If the original initiator reissues the captured read before the data is back, it gets retry, and only one backend read is issued for that capture.
- R4: `be_req` stays high with an unchanged `be_addr` for as long as `be_wait` is high. It drops on the edge after the first cycle in which `be_wait` is low, so it is high for exactly (wait cycles + 1) cycles.
- R5: Once the data is held, any read that does not match both the captured ID and the captured address gets retry, and no new backend read starts.
- R6: Once the data is held, the matching read gets complete (code 10) in the same cycle, with `rsp_data` equal to the word the backend returned. The controller is idle again from the next cycle, so the next read starts a new capture.
- R7: A read that was refused earlier gets no precedence. When it arrives while the controller is idle, it gets retry and starts its own backend read at its own address.
- R8: `rsp_code` is 00 in every cycle without `req_valid`, and it never takes the value 11.
- R9: A synchronous reset returns the controller to idle and drops the captured ID, address and data. A matching read after reset gets retry and starts a fresh backend read.
- R10: With `discard_en` high, held data is kept for `discard_limit`+1 cycles. A matching read in the last of those cycles completes. A matching read one cycle later is treated as a new read.
- R11: With `discard_en` low, held data waits for its initiator for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A read request is present this cycle |
| req_id | input | ID_W | Identity of the requesting initiator |
| req_addr | input | ADDR_W | Read address |
| rsp_code | output | 2 | 00 none, 01 retry, 10 complete with data |
| rsp_data | output | DATA_W | Read data, valid with code 10, zero otherwise |
| be_req | output | 1 | Backend read request |
| be_addr | output | ADDR_W | Backend read address |
| be_wait | input | 1 | Backend stalls the request |
| be_rvalid | input | 1 | Backend read data valid |
| be_rdata | input | DATA_W | Backend read data |
| discard_en | input | 1 | Enable the discard timer |
| discard_limit | input | TMR_W | Discard window length minus one, in cycles |

## Verification
The bench reissues the captured read before the data is back. A design that trusts a matching ID and address alone would complete it with stale data, or would start a second backend fetch. It also sends reads that match the captured request in only one field. A design that compares one field would hand data to the wrong initiator. The discard window is probed on both sides of its last cycle, and an off-by-one would either complete a read that should be retried or retry one that should complete. A reset taken while data is held must not let the old data escape, and a read that was refused earlier must start its own fetch, not inherit anything.

// File: rtl/delayed_read_ctrl.sv
module delayed_read_ctrl #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_data,
  output logic              be_req,
  output logic [ADDR_W-1:0] be_addr,
  input  logic              be_wait,
  input  logic              be_rvalid,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic              discard_en,
  input  logic [TMR_W-1:0]  discard_limit
);
  localparam logic [1:0] RSP_NONE  = 2'b00;
  localparam logic [1:0] RSP_RETRY = 2'b01;
  localparam logic [1:0] RSP_DONE  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_READY} state_t;

  state_t             st;
  logic [ID_W-1:0]    hold_id;
  logic [ADDR_W-1:0]  hold_addr;
  logic [DATA_W-1:0]  hold_data;
  logic [TMR_W-1:0]   age;

  wire hit       = req_valid && req_id == hold_id && req_addr == hold_addr;
  wire collect   = st == S_READY && hit;
  wire expire    = st == S_READY && !hit && discard_en && age == discard_limit;
  wire take_data = st == S_FETCH && be_rvalid && (!be_req || !be_wait);

  assign rsp_code = !req_valid ? RSP_NONE : (collect ? RSP_DONE : RSP_RETRY);
  assign rsp_data = collect ? hold_data : '0;
  assign be_addr  = hold_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      hold_id   <= '0;
      hold_addr <= '0;
      hold_data <= '0;
      be_req    <= 1'b0;
      age       <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          hold_id   <= req_id;
          hold_addr <= req_addr;
          be_req    <= 1'b1;
          st        <= S_FETCH;
        end
        S_FETCH: begin
          if (be_req && !be_wait) be_req <= 1'b0;
          if (take_data) begin
            hold_data <= be_rdata;
            age       <= '0;
            st        <= S_READY;
          end
        end
        S_READY: begin
          if (collect || expire) begin
            hold_data <= '0;
            st        <= S_IDLE;
          end else begin
            age <= age + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delayed_read_ctrl_chk.sv
module delayed_read_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        rsp_code,
  input logic              be_req,
  input logic              be_wait,
  input logic [ADDR_W-1:0] be_addr
);
  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    be_req && be_wait |=> be_req && $stable(be_addr));
  // R4
  release_req_chk: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_wait |=> !be_req);
  // R8
  quiet_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> rsp_code == 2'b00);
  // R8
  legal_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_code != 2'b11);
  // R1
  launch_after_retry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(be_req) |-> $past(req_valid && rsp_code == 2'b01));
  // R3
  no_done_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    be_req |-> rsp_code != 2'b10);
  // R6
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_code == 2'b10 |=> rsp_code != 2'b10);
endmodule

bind delayed_read_ctrl delayed_read_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_code(rsp_code),
  .be_req(be_req), .be_wait(be_wait), .be_addr(be_addr)
);

// File: tb/tb_delayed_read_ctrl.sv
module tb_delayed_read_ctrl;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 32, TMR_W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        rsp_code;
  logic [DATA_W-1:0] rsp_data;
  logic              be_req;
  logic [ADDR_W-1:0] be_addr;
  logic              be_wait;
  logic              be_rvalid = 1'b0;
  logic [DATA_W-1:0] be_rdata = '0;
  logic              discard_en = 1'b0;
  logic [TMR_W-1:0]  discard_limit = '0;

  delayed_read_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .rsp_code(rsp_code), .rsp_data(rsp_data), .be_req(be_req), .be_addr(be_addr),
    .be_wait(be_wait), .be_rvalid(be_rvalid), .be_rdata(be_rdata),
    .discard_en(discard_en), .discard_limit(discard_limit)
  );

  int total = 0, bad = 0;
  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // backend model
  int wait_cfg = 2, lat_cfg = 3;
  int wcnt = 0, lcnt = 0, launches = 0, reqhi = 0, last_reqhi = 0;
  bit pend = 0, addr_moved = 0;
  logic [ADDR_W-1:0] last_addr = '0, paddr = '0, prev_addr = '0;
  assign be_wait = be_req && (wcnt < wait_cfg);

  always @(posedge clk) begin
    be_rvalid <= 1'b0;
    if (rst) begin
      wcnt <= 0; pend <= 0; reqhi <= 0;
    end else begin
      if (be_req) begin
        if (reqhi > 0 && be_addr != prev_addr) addr_moved <= 1;
        prev_addr <= be_addr;
        if (be_wait) begin
          wcnt <= wcnt + 1; reqhi <= reqhi + 1;
        end else begin
          launches <= launches + 1; last_addr <= be_addr; last_reqhi <= reqhi + 1;
          reqhi <= 0; wcnt <= 0; pend <= 1; lcnt <= 0; paddr <= be_addr;
        end
      end
      if (pend) begin
        if (lcnt == lat_cfg) begin
          be_rvalid <= 1'b1; be_rdata <= {paddr, ~paddr}; pend <= 0;
        end else lcnt <= lcnt + 1;
      end
    end
  end

  // scoreboard
  logic [1:0]        q_code[$];
  logic [DATA_W-1:0] q_data[$];
  string             q_tag[$];

  always @(negedge clk) if (!rst) begin
    if (req_valid) begin
      if (q_code.size() == 0) check(0, "scoreboard underflow", 0, 1);
      else begin
        automatic logic [1:0] c = q_code.pop_front();
        automatic logic [DATA_W-1:0] d = q_data.pop_front();
        automatic string t = q_tag.pop_front();
        check(rsp_code == c, t, rsp_code, c);
        if (c == 2'b10) check(rsp_data == d, {t, " data"}, rsp_data, d);
      end
    end else check(rsp_code == 2'b00, "R8 no request gives code 00", rsp_code, 0);
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic rd(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                    input logic [1:0] code, input string tag);
    req_valid = 1'b1; req_id = id; req_addr = a;
    q_code.push_back(code); q_data.push_back({a, ~a}); q_tag.push_back(tag);
    tick;
    req_valid = 1'b0;
  endtask

  task automatic wait_data;
    while (!be_rvalid) tick;
    tick;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  int l0;
  initial begin
    repeat (3) tick;
    check(rsp_code == 2'b00 && be_req == 1'b0, "R9 reset state", {rsp_code, be_req}, 0);
    rst = 1'b0;
    tick;

    rd(4'd1, 16'h0040, 2'b01, "R1 idle read retried");
    check(be_req == 1'b1 && be_addr == 16'h0040, "R1 launch address", be_addr, 16'h0040);
    wait_data;
    check(launches == 1, "R1 one launch", launches, 1);
    check(last_reqhi == wait_cfg + 1, "R4 request held through wait", last_reqhi, wait_cfg + 1);
    check(addr_moved == 0, "R4 address stable", addr_moved, 0);
    rd(4'd1, 16'h0040, 2'b10, "R6 matching reissue completes");
    rd(4'd2, 16'h0080, 2'b01, "R6 idle again new read retried");
    check(be_req == 1'b1 && be_addr == 16'h0080, "R6 new launch after collect", be_addr, 16'h0080);

    l0 = launches;
    rd(4'd3, 16'h0080, 2'b01, "R2 other initiator retried");
    rd(4'd2, 16'h0084, 2'b01, "R2 other address retried");
    rd(4'd2, 16'h0080, 2'b01, "R3 early reissue retried");
    check(be_addr == 16'h0080, "R2 captured address kept", be_addr, 16'h0080);
    wait_data;
    check(launches == l0 + 1, "R3 single backend read", launches, l0 + 1);
    check(last_addr == 16'h0080, "R2 fetched address", last_addr, 16'h0080);
    rd(4'd3, 16'h0080, 2'b01, "R5 other initiator after data");
    rd(4'd2, 16'h0088, 2'b01, "R5 other address after data");
    check(be_req == 1'b0 && launches == l0 + 1, "R5 nothing launched", launches, l0 + 1);
    rd(4'd2, 16'h0080, 2'b10, "R6 second collect");

    rd(4'd3, 16'h0080, 2'b01, "R7 refused read starts fresh");
    check(be_req == 1'b1 && be_addr == 16'h0080, "R7 own launch", be_addr, 16'h0080);
    wait_data;
    rd(4'd3, 16'h0080, 2'b10, "R7 collect");

    wait_cfg = 0; lat_cfg = 0;
    rd(4'd5, 16'h0010, 2'b01, "R1 zero wait read");
    wait_data;
    rst = 1'b1; tick; rst = 1'b0;
    l0 = launches;
    rd(4'd5, 16'h0010, 2'b01, "R9 capture dropped by reset");
    check(be_req == 1'b1, "R9 fresh launch", be_req, 1);
    wait_data;
    check(launches == l0 + 1, "R9 launch count", launches, l0 + 1);
    rd(4'd5, 16'h0010, 2'b10, "R9 fresh collect");

    discard_en = 1'b1; discard_limit = 12'd3;
    rd(4'd6, 16'h0020, 2'b01, "R10 window read");
    wait_data;
    repeat (3) tick;
    rd(4'd6, 16'h0020, 2'b10, "R10 last cycle of window completes");
    rd(4'd7, 16'h0024, 2'b01, "R10 second read");
    wait_data;
    repeat (4) tick;
    l0 = launches;
    rd(4'd7, 16'h0024, 2'b01, "R10 dropped after window");
    check(be_req == 1'b1, "R10 relaunch after discard", be_req, 1);
    wait_data;
    rd(4'd7, 16'h0024, 2'b10, "R10 collect after relaunch");

    discard_en = 1'b0;
    rd(4'd8, 16'h0030, 2'b01, "R11 read");
    wait_data;
    repeat (40) tick;
    rd(4'd8, 16'h0030, 2'b10, "R11 data held without timer");
    tick;
    check(q_code.size() == 0, "scoreboard drained", q_code.size(), 0);
    finish_run;
  end
endmodule